// File: doc/BRIEF.md
# Per-Connection TCP Timer Manager

This block keeps the protocol deadlines of many TCP connections in one shared engine. Every connection owns seven timer slots, one for each timer class: 0 connection setup, 1 retransmission, 2 delayed acknowledgement, 3 zero-window probe, 4 keep-alive, 5 FIN-WAIT-2 hold and 6 TIME-WAIT hold. The connection engine talks to it through a command port. Each command names a connection, a class and a relative timeout in ticks, and it either arms the slot or cancels it. The block takes a command on every clock and never pushes back, so the pipeline that feeds it always sees the same fixed cost per operation.

A prescaler turns the clock into a fine-grained tick count. Deadlines are stored as absolute tick values and compared against the current tick in a way that is safe across counter wrap. A scanner visits one slot per clock in round-robin order. A slot that is due is cleared and reported as an event of connection and class. Events wait in a small FIFO with a valid/ready output, and the scanner halts while that FIFO is full.

Top module: `tcp_timer_engine`

## Requirements
- R1: While reset is asserted and right after it is released, `evt_valid` is low and `now_tick` reads 0.
- R2: `now_tick` increases by one every PRESCALE clocks and wraps modulo 2^(TIMEOUT_W+1).
- R3: An arm command (`cmd_op` = 2'b01) makes slot {conn, class} pending with deadline `now_tick` + `cmd_timeout`. The slot later yields exactly one event carrying that conn and class. The event is not reported before the deadline tick, and while `evt_ready` is high it is reported within one scan pass after the deadline (7·2^CONN_W clocks).
- R4: Arming a slot that is already pending replaces its deadline, and only the new deadline produces an event.
- R5: A cancel command (`cmd_op` = 2'b10) removes a pending slot so it never reports. Cancelling a slot that is not pending changes nothing.
- R6: Commands with `cmd_op` 2'b00 or 2'b11, and commands with class 7, are ignored and leave every slot unchanged. No event ever carries class 7.
- R7: A slot reports at most once per arm. After its event the slot stays silent until it is armed again.
- R8: When a command targets the slot the scanner is visiting in the same clock, the command takes effect and that slot reports nothing in that clock.
- R9: The deadline comparison is correct when the deadline wraps past the top of the tick counter. Such a timer neither fires early nor is lost.
- R10: While `evt_valid` is high and `evt_ready` is low, the event outputs hold steady. The scanner reports nothing while the FIFO is full, so no expiry is dropped under back-pressure.
- R11: Commands are accepted on consecutive clocks without any ready signal, and each one takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this clock |
| cmd_op | input | 2 | 01 arm, 10 cancel, others ignored |
| cmd_conn | input | CONN_W | Connection index |
| cmd_type | input | 3 | Timer class 0..6 |
| cmd_timeout | input | TIMEOUT_W | Relative timeout in ticks |
| evt_valid | output | 1 | Expiry event available |
| evt_ready | input | 1 | Consumer accepts the event |
| evt_conn | output | CONN_W | Connection of the expired timer |
| evt_type | output | 3 | Class of the expired timer |
| now_tick | output | TIMEOUT_W+1 | Current tick count |

## Verification
The assertions check four properties on every clock: the tick steps and holds correctly, a held event stays stable under back-pressure, nothing is reported into a full FIFO, and a command on the slot being scanned suppresses that slot's report. Class 7 is also checked never to be reported. The bench scenarios cover what only a sequence of operations can show. Deadlines must be honoured, including across counter wrap, and rearms must replace older deadlines. Cancels, including cancels of idle slots, and reserved opcodes must leave the right slots alone, and no slot may fire twice. The bench also times a rearm so that it lands in the exact clock the scanner revisits a due slot, and it holds back the consumer to show that a burst of expiries queues without loss.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int CLASS_W   = 3;
  localparam int NUM_CLASS = 7;

  typedef enum logic [1:0] {
    OP_IDLE   = 2'b00,
    OP_ARM    = 2'b01,
    OP_CANCEL = 2'b10,
    OP_RSVD   = 2'b11
  } tmr_op_e;

  typedef enum logic [CLASS_W-1:0] {
    CL_SETUP     = 3'd0,
    CL_RETX      = 3'd1,
    CL_DELACK    = 3'd2,
    CL_PROBE     = 3'd3,
    CL_KEEPALIVE = 3'd4,
    CL_FINWAIT2  = 3'd5,
    CL_TIMEWAIT  = 3'd6,
    CL_NONE      = 3'd7
  } tmr_class_e;

  localparam logic [CLASS_W-1:0] LAST_CLASS = CLASS_W'(NUM_CLASS - 1);

endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int PRESCALE = 4,
  parameter int TICK_W   = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              tick_pulse,
  output logic [TICK_W-1:0] now_tick
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] PLAST = PW'(PRESCALE - 1);

  logic [PW-1:0] pre_q;

  generate
    if (PRESCALE > 1) begin : g_div
      assign tick_pulse = (pre_q == PLAST);
      always_ff @(posedge clk) begin
        if (!rst_n)          pre_q <= '0;
        else if (tick_pulse) pre_q <= '0;
        else                 pre_q <= pre_q + 1'b1;
      end
    end else begin : g_nodiv
      assign tick_pulse = 1'b1;
      always_ff @(posedge clk) pre_q <= '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)          now_tick <= '0;
    else if (tick_pulse) now_tick <= now_tick + 1'b1;
  end
endmodule

// File: rtl/tmr_scan_ptr.sv
module tmr_scan_ptr import tmr_pkg::*; #(
  parameter int CONN_W      = 6,
  parameter bit SKIP_UNUSED = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               advance,
  output logic [CONN_W-1:0]  scan_conn,
  output logic [CLASS_W-1:0] scan_type
);
  logic [CONN_W-1:0]  conn_nx;
  logic [CLASS_W-1:0] type_nx;

  generate
    if (SKIP_UNUSED) begin : g_skip
      always_comb begin
        if (scan_type == LAST_CLASS) begin
          conn_nx = scan_conn + 1'b1;
          type_nx = '0;
        end else begin
          conn_nx = scan_conn;
          type_nx = scan_type + 1'b1;
        end
      end
    end else begin : g_full
      always_comb {conn_nx, type_nx} = {scan_conn, scan_type} + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scan_conn <= '0;
      scan_type <= '0;
    end else if (advance) begin
      scan_conn <= conn_nx;
      scan_type <= type_nx;
    end
  end
endmodule

// File: rtl/tmr_slot_table.sv
module tmr_slot_table import tmr_pkg::*; #(
  parameter int CONN_W    = 6,
  parameter int TIMEOUT_W = 16,
  parameter int TICK_W    = TIMEOUT_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [1:0]           cmd_op,
  input  logic [CONN_W-1:0]    cmd_conn,
  input  logic [CLASS_W-1:0]   cmd_type,
  input  logic [TIMEOUT_W-1:0] cmd_timeout,
  input  logic [TICK_W-1:0]    now_tick,
  input  logic [CONN_W-1:0]    scan_conn,
  input  logic [CLASS_W-1:0]   scan_type,
  input  logic                 scan_en,
  output logic                 fire,
  output logic                 cmd_hit_scan
);
  localparam int SLOT_W = CONN_W + CLASS_W;
  localparam int NSLOT  = 1 << SLOT_W;

  // true once the current tick has reached or passed the deadline,
  // judged over half the counter range so wrap is harmless
  function automatic logic deadline_reached(input logic [TICK_W-1:0] now_v,
                                            input logic [TICK_W-1:0] dl_v);
    logic [TICK_W-1:0] diff;
    diff = now_v - dl_v;
    return ~diff[TICK_W-1];
  endfunction

  function automatic logic [TICK_W-1:0] deadline_from(input logic [TICK_W-1:0]    now_v,
                                                      input logic [TIMEOUT_W-1:0] rel_v);
    return now_v + TICK_W'(rel_v);
  endfunction

  logic [NSLOT-1:0]  pending;
  logic [TICK_W-1:0] deadline [NSLOT];

  logic [SLOT_W-1:0] cmd_slot;
  logic [SLOT_W-1:0] scan_slot;
  logic              cmd_ok;
  logic              cmd_arm;
  logic              scan_due;

  assign cmd_slot  = {cmd_conn, cmd_type};
  assign scan_slot = {scan_conn, scan_type};
  assign cmd_ok    = cmd_valid && (cmd_type != CL_NONE) &&
                     ((cmd_op == OP_ARM) || (cmd_op == OP_CANCEL));
  assign cmd_arm   = cmd_ok && (cmd_op == OP_ARM);

  assign cmd_hit_scan = cmd_ok && (cmd_slot == scan_slot);
  assign scan_due     = pending[scan_slot] && deadline_reached(now_tick, deadline[scan_slot]);
  assign fire         = scan_en && scan_due && !cmd_hit_scan;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= '0;
    end else begin
      if (fire)   pending[scan_slot] <= 1'b0;
      if (cmd_ok) pending[cmd_slot]  <= cmd_arm;
    end
  end

  always_ff @(posedge clk) begin
    if (cmd_arm) deadline[cmd_slot] <= deadline_from(now_tick, cmd_timeout);
  end
endmodule

// File: rtl/tmr_event_fifo.sv
module tmr_event_fifo #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             full,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0]      wptr, rptr;

  assign empty = (wptr == rptr);
  assign full  = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
  assign rdata = mem[rptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (push && !full) wptr <= wptr + 1'b1;
      if (pop && !empty) rptr <= rptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full) mem[wptr[AW-1:0]] <= wdata;
  end
endmodule

// File: rtl/tcp_timer_engine.sv
module tcp_timer_engine import tmr_pkg::*; #(
  parameter int CONN_W      = 6,
  parameter int TIMEOUT_W   = 16,
  parameter int PRESCALE    = 4,
  parameter int FIFO_DEPTH  = 4,
  parameter bit SKIP_UNUSED = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  input  logic [1:0]             cmd_op,
  input  logic [CONN_W-1:0]      cmd_conn,
  input  logic [2:0]             cmd_type,
  input  logic [TIMEOUT_W-1:0]   cmd_timeout,
  output logic                   evt_valid,
  input  logic                   evt_ready,
  output logic [CONN_W-1:0]      evt_conn,
  output logic [2:0]             evt_type,
  output logic [TIMEOUT_W:0]     now_tick
);
  localparam int TICK_W = TIMEOUT_W + 1;
  localparam int EVT_W  = CONN_W + CLASS_W;

  // named internal events, also watched by the bound checker
  logic                tick_pulse;
  logic                fire;
  logic                fifo_full;
  logic                fifo_empty;
  logic                cmd_hit_scan;
  logic [CONN_W-1:0]   scan_conn;
  logic [CLASS_W-1:0]  scan_type;
  logic [EVT_W-1:0]    evt_word;

  tmr_tick_gen #(.PRESCALE(PRESCALE), .TICK_W(TICK_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_pulse(tick_pulse), .now_tick(now_tick)
  );

  tmr_scan_ptr #(.CONN_W(CONN_W), .SKIP_UNUSED(SKIP_UNUSED)) u_scan (
    .clk(clk), .rst_n(rst_n), .advance(!fifo_full),
    .scan_conn(scan_conn), .scan_type(scan_type)
  );

  tmr_slot_table #(.CONN_W(CONN_W), .TIMEOUT_W(TIMEOUT_W), .TICK_W(TICK_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_conn(cmd_conn),
    .cmd_type(cmd_type), .cmd_timeout(cmd_timeout),
    .now_tick(now_tick), .scan_conn(scan_conn), .scan_type(scan_type),
    .scan_en(!fifo_full), .fire(fire), .cmd_hit_scan(cmd_hit_scan)
  );

  tmr_event_fifo #(.WIDTH(EVT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(fire), .wdata({scan_conn, scan_type}),
    .pop(evt_valid && evt_ready), .rdata(evt_word),
    .full(fifo_full), .empty(fifo_empty)
  );

  assign evt_valid = !fifo_empty;
  assign evt_conn  = evt_word[EVT_W-1:CLASS_W];
  assign evt_type  = evt_word[CLASS_W-1:0];
endmodule

// File: rtl/tcp_timer_engine_chk.sv
module tcp_timer_engine_chk #(
  parameter int CONN_W = 6,
  parameter int TICK_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evt_valid,
  input logic              evt_ready,
  input logic [CONN_W-1:0] evt_conn,
  input logic [2:0]        evt_type,
  input logic [TICK_W-1:0] now_tick,
  input logic              tick_pulse,
  input logic              fire,
  input logic              fifo_full,
  input logic [2:0]        scan_type,
  input logic              cmd_hit_scan
);
  assert_tick_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_pulse |=> now_tick == TICK_W'($past(now_tick) + 1'b1));

  assert_tick_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_pulse |=> $stable(now_tick));

  assert_no_class7_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> scan_type != 3'd7);

  assert_cmd_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_hit_scan |-> !fire);

  assert_no_fire_when_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !fire);

  assert_evt_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !evt_ready) |=> evt_valid && $stable(evt_conn) && $stable(evt_type));
endmodule

bind tcp_timer_engine tcp_timer_engine_chk #(.CONN_W(CONN_W), .TICK_W(TICK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ready(evt_ready),
  .evt_conn(evt_conn), .evt_type(evt_type), .now_tick(now_tick),
  .tick_pulse(tick_pulse), .fire(fire), .fifo_full(fifo_full),
  .scan_type(scan_type), .cmd_hit_scan(cmd_hit_scan)
);

// File: tb/tcp_timer_engine_test.sv
`timescale 1ns/1ps
module tcp_timer_engine_test;
  localparam int CONN_W    = 4;
  localparam int TIMEOUT_W = 10;
  localparam int TICK_W    = TIMEOUT_W + 1;
  localparam int PRESCALE  = 2;
  localparam int TMASK     = (1 << TICK_W) - 1;
  localparam int HALF      = 1 << (TICK_W - 1);
  localparam int PASS_CYC  = 7 * (1 << CONN_W);
  localparam int LATE_MAX  = PASS_CYC / PRESCALE + 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                 rst_n, cmd_valid, evt_valid, evt_ready;
  logic [1:0]           cmd_op;
  logic [CONN_W-1:0]    cmd_conn, evt_conn;
  logic [2:0]           cmd_type, evt_type;
  logic [TIMEOUT_W-1:0] cmd_timeout;
  logic [TIMEOUT_W:0]   now_tick;

  tcp_timer_engine #(.CONN_W(CONN_W), .TIMEOUT_W(TIMEOUT_W), .PRESCALE(PRESCALE),
                     .FIFO_DEPTH(4), .SKIP_UNUSED(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_conn(cmd_conn), .cmd_type(cmd_type), .cmd_timeout(cmd_timeout),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_conn(evt_conn),
    .evt_type(evt_type), .now_tick(now_tick)
  );

  int    n_checks = 0, n_fail = 0;
  int    q_slot[$];
  int    q_dl[$];
  bit    q_late[$];
  string q_req[$];
  bit    strict_order = 1'b1;

  function automatic void check(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endfunction

  function automatic int find_slot(int s);
    for (int i = 0; i < q_slot.size(); i++) if (q_slot[i] == s) return i;
    return -1;
  endfunction

  function automatic void drop_slot(int s);
    int k;
    k = find_slot(s);
    while (k >= 0) begin
      q_slot.delete(k); q_dl.delete(k); q_late.delete(k); q_req.delete(k);
      k = find_slot(s);
    end
  endfunction

  function automatic void expect_evt(int conn, int typ, int to, string req, bit late_ok);
    drop_slot(conn * 8 + typ);
    q_slot.push_back(conn * 8 + typ);
    q_dl.push_back((int'(now_tick) + to) & TMASK);
    q_late.push_back(late_ok);
    q_req.push_back(req);
  endfunction

  task automatic raw(int op, int conn, int typ, int to);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'(op); cmd_conn = CONN_W'(conn);
    cmd_type = 3'(typ); cmd_timeout = TIMEOUT_W'(to);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic arm(int conn, int typ, int to, string req, bit late_ok);
    @(negedge clk);
    expect_evt(conn, typ, to, req, late_ok);
    cmd_valid = 1'b1; cmd_op = 2'b01; cmd_conn = CONN_W'(conn);
    cmd_type = 3'(typ); cmd_timeout = TIMEOUT_W'(to);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic cancel(int conn, int typ);
    drop_slot(conn * 8 + typ);
    raw(2, conn, typ, 0);
  endtask

  task automatic wait_drain(int maxc, string req);
    int c = 0;
    while (q_slot.size() != 0 && c < maxc) begin @(negedge clk); c++; end
    check(q_slot.size() == 0, req, "events still outstanding", q_slot.size(), 0);
  endtask

  task automatic quiet(int n, string req);
    bit seen = 1'b0;
    repeat (n) begin @(negedge clk); seen |= evt_valid; end
    check(!seen, req, "spurious event in quiet window", int'(seen), 0);
  endtask

  // monitor: pops the scoreboard as events are accepted
  always @(negedge clk) begin
    int s, k, el;
    if (rst_n && evt_valid && evt_ready) begin
      s = int'(evt_conn) * 8 + int'(evt_type);
      k = find_slot(s);
      if (k < 0) begin
        check(1'b0, "R7", "unexpected event slot", s, -1);
      end else begin
        if (strict_order) check(k == 0, q_req[k], "event order slot", s, q_slot[0]);
        el = (int'(now_tick) - q_dl[k]) & TMASK;
        check(el < HALF, q_req[k], "event before deadline (ticks past)", el, 0);
        if (q_late[k]) check(el <= LATE_MAX, q_req[k], "event latency ticks", el, LATE_MAX);
        q_slot.delete(k); q_dl.delete(k); q_late.delete(k); q_req.delete(k);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "WD", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int t0, c;
    logic [CONN_W-1:0] hc;
    logic [2:0] ht;
    bit steady;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_conn = '0;
    cmd_type = '0; cmd_timeout = '0; evt_ready = 1'b1;
    repeat (4) @(negedge clk);
    check(now_tick == 0, "R1", "tick in reset", int'(now_tick), 0);
    check(!evt_valid, "R1", "evt_valid in reset", int'(evt_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!evt_valid, "R1", "evt_valid after reset", int'(evt_valid), 0);

    // R2 tick rate
    t0 = int'(now_tick);
    repeat (20) @(negedge clk);
    check(((int'(now_tick) - t0) & TMASK) == 20 / PRESCALE, "R2", "ticks in 20 clocks",
          (int'(now_tick) - t0) & TMASK, 20 / PRESCALE);

    // R3 ordered expiries with spread deadlines
    arm(3, 1, 20, "R3", 1'b1);
    arm(7, 6, 120, "R3", 1'b1);
    arm(12, 2, 220, "R3", 1'b1);
    wait_drain(800, "R3");
    quiet(250, "R7");

    // R4 rearm replaces the deadline
    arm(5, 2, 10, "R4", 1'b1);
    arm(5, 2, 150, "R4", 1'b1);
    wait_drain(600, "R4");
    quiet(250, "R4");

    // R5 cancel pending and cancel idle
    arm(6, 3, 30, "R5", 1'b1);
    cancel(6, 3);
    cancel(9, 5);
    arm(7, 0, 80, "R5", 1'b1);
    wait_drain(400, "R5");
    quiet(250, "R5");

    // R6 reserved opcodes and class 7 leave state alone
    arm(2, 4, 100, "R6", 1'b1);
    raw(0, 2, 4, 1);
    raw(3, 2, 4, 1);
    raw(1, 2, 7, 1);
    raw(2, 2, 7, 0);
    wait_drain(500, "R6");
    quiet(250, "R6");

    // R8 rearm lands in the clock the scanner revisits a due slot
    arm(11, 5, 0, "R8", 1'b1);
    c = 0;
    while (!evt_valid && c < 400) begin @(negedge clk); c++; end
    arm(11, 5, 0, "R8", 1'b1);
    repeat (PASS_CYC - 4) @(negedge clk);
    arm(11, 5, 300, "R8", 1'b1);
    wait_drain(900, "R8");
    quiet(250, "R8");

    // R11 back-to-back commands
    strict_order = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      expect_evt(i, 6, 50, "R11", 1'b1);
      cmd_valid = 1'b1; cmd_op = 2'b01; cmd_conn = CONN_W'(i);
      cmd_type = 3'd6; cmd_timeout = TIMEOUT_W'(50);
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    wait_drain(600, "R11");
    quiet(250, "R7");

    // R10 back-pressure: more expiries than FIFO entries
    evt_ready = 1'b0;
    for (int i = 0; i < 10; i++) arm(i, 1, 1, "R10", 1'b0);
    repeat (300) @(negedge clk);
    check(evt_valid, "R10", "event held under back-pressure", int'(evt_valid), 1);
    hc = evt_conn; ht = evt_type; steady = 1'b1;
    repeat (20) begin
      @(negedge clk);
      if (!evt_valid || evt_conn != hc || evt_type != ht) steady = 1'b0;
    end
    check(steady, "R10", "held event stable", int'(steady), 1);
    evt_ready = 1'b1;
    wait_drain(600, "R10");
    quiet(250, "R10");

    // R9 deadline beyond counter wrap
    strict_order = 1'b1;
    c = 0;
    while (int'(now_tick) != TMASK - 17 && c < 5000) begin @(negedge clk); c++; end
    arm(9, 4, 40, "R9", 1'b1);
    wait_drain(400, "R9");
    quiet(250, "R9");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule